// File: doc/BRIEF.md
# MDIO Management Command Controller

This block runs clause-22 management transactions to external PHY or switch registers on a two-wire management bus (MDC clock, MDIO data). Software sees three 16-bit registers on a simple write/read port. It loads the word to be written into a data register. It then writes a command word that holds a request bit (read or write), a 5-bit PHY address and a 5-bit register index. The block shifts the frame out on MDIO, which is driven through an output-enable so that the pin can be released. MDC is the system clock divided by a parameter.

The request bit in the command register is also the busy flag. It reads back as set for as long as the frame is on the wire, and the hardware clears it when the last bit is done. Software polls that bit. A read places the 16 bits returned by the PHY into a result register.

A frame takes a fixed 128 × `CLK_DIV` system cycles. With the default divider that is 512 cycles, far inside a poll budget of a couple of thousand register reads.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset, the command, result and write-data registers read 0, MDC is low and MDIO is released (`mdio_oe` = 0).
- R2: A write to the command offset 0x20 while idle starts a transaction if bit 13 (read request) or bit 14 (write request) is set. If both are set, a read is performed and only bit 13 reads back as set. The request bit reads back set from the cycle after the write. The PHY address is held in bits 12:8 and the register index in bits 4:0, and all other bits read 0.
- R3: A write frame, sampled on rising MDC edges, is 64 bits: 32 ones, start 01, opcode 01, PHY address, register index, turnaround 10, and then the 16 bits of the write-data register at offset 0x28. Every field is sent MSB first.
- R4: A read frame sends 32 ones, 01, opcode 10, PHY address and register index. It releases MDIO for the last 18 bit times (turnaround and data). It samples 16 bits on rising MDC, MSB first, into the result register at offset 0x24.
- R5: Between frames MDC is low and MDIO is released. Each MDC half period lasts `CLK_DIV` system cycles.
- R6: MDIO output data changes only while MDC is low.
- R7: The request bit clears exactly 128 × `CLK_DIV` cycles after the command is accepted. The address and index fields keep their values after it clears.
- R8: A command write while busy is ignored. A command write with neither request bit set is ignored, and the command register keeps its contents.
- R9: Reads at 0x28 return the write-data register, and reads at any offset other than 0x20, 0x24 and 0x28 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write offset |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 8 | Register read offset |
| rd_data | output | 16 | Register read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The assertions assume that reset is applied before the first command. They assume that `mdio_i` has a defined value whenever MDC rises during the read data phase, and that the register port never writes to two offsets in one cycle. The bench keeps to these rules in the following ways. A PHY model drives `mdio_i` high when idle and changes it only on falling MDC. All register accesses go through one task that issues a single write per cycle. Random commands are mixed with directed cases: both request bits set, neither bit set, a command issued mid-frame, and extreme address and data values.

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl #(
  parameter int CLK_DIV  = 4,
  parameter int PRE_LEN  = 32,
  parameter logic [7:0] CMD_OFS  = 8'h20,
  parameter logic [7:0] RES_OFS  = 8'h24,
  parameter logic [7:0] WDAT_OFS = 8'h28
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [7:0]  rd_addr,
  output logic [15:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FLEN    = PRE_LEN + 32;
  localparam int TA_POS  = PRE_LEN + 14;
  localparam int DAT_POS = PRE_LEN + 16;
  localparam int IW      = $clog2(FLEN);
  localparam int DCW     = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [15:0]     cmd_q, wdat_q, res_q, rsh_q;
  logic [FLEN-1:0] tx_q;
  logic [IW-1:0]   idx_q;
  logic [DCW-1:0]  div_q;
  logic            mdc_q;

  wire busy  = cmd_q[14] | cmd_q[13];
  wire is_rd = cmd_q[13];
  wire start = wr_en && (wr_addr == CMD_OFS) && !busy && (wr_data[13] || wr_data[14]);
  wire tick  = busy && (div_q == DCW'(CLK_DIV - 1));
  wire last  = (idx_q == IW'(FLEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      wdat_q <= '0;
      res_q  <= '0;
      rsh_q  <= '0;
      tx_q   <= '0;
      idx_q  <= '0;
      div_q  <= '0;
      mdc_q  <= 1'b0;
    end else begin
      if (wr_en && wr_addr == WDAT_OFS) wdat_q <= wr_data;
      if (start) begin
        cmd_q <= {1'b0, wr_data[14] & ~wr_data[13], wr_data[13], wr_data[12:8], 3'b000, wr_data[4:0]};
        tx_q  <= {{PRE_LEN{1'b1}}, 2'b01, (wr_data[13] ? 2'b10 : 2'b01),
                  wr_data[12:8], wr_data[4:0], 2'b10, wdat_q};
        idx_q <= '0;
        div_q <= '0;
        mdc_q <= 1'b0;
      end else if (busy) begin
        div_q <= tick ? '0 : div_q + 1'b1;
        if (tick) begin
          mdc_q <= ~mdc_q;
          if (!mdc_q) begin
            if (is_rd && idx_q >= IW'(DAT_POS)) rsh_q <= {rsh_q[14:0], mdio_i};
          end else if (last) begin
            cmd_q[14:13] <= 2'b00;
            if (is_rd) res_q <= rsh_q;
          end else begin
            idx_q <= idx_q + 1'b1;
            tx_q  <= {tx_q[FLEN-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign mdc     = mdc_q;
  assign mdio_o  = tx_q[FLEN-1];
  assign mdio_oe = busy && !(is_rd && idx_q >= IW'(TA_POS));

  always_comb begin
    case (rd_addr)
      CMD_OFS:  rd_data = cmd_q;
      RES_OFS:  rd_data = res_q;
      WDAT_OFS: rd_data = wdat_q;
      default:  rd_data = 16'h0000;
    endcase
  end
endmodule

// File: rtl/mdio_cmd_chk.sv
module mdio_cmd_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic [15:0] cmd_q,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  a_r5_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  a_r5_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);
  a_r6_data_steady_mdc_high: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> $stable(mdio_o));
  a_r8_cmd_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd_q));
  a_r3_frame_opens_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mdio_oe && mdio_o && !mdc));
endmodule

bind mdio_cmd_ctrl mdio_cmd_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cmd_q(cmd_q),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_cmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module mdio_cmd_ctrl_tb_top;
  localparam int DIV = 4;
  logic clk = 0, rst_n = 0, wr_en = 0, mdio_i = 1;
  logic [7:0] wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic mdc, mdio_o, mdio_oe;
  int checks = 0, errors = 0, cnt = 0, r6_bad = 0;
  logic [63:0] cap = 0, oev = 0;
  logic [15:0] cur_resp = 0;
  bit finished = 0;

  mdio_cmd_ctrl #(.CLK_DIV(DIV)) dut_i (.*);

  always #2 clk = ~clk;

  always @(posedge mdc) begin
    cap = {cap[62:0], mdio_oe ? mdio_o : 1'b1};
    oev = {oev[62:0], mdio_oe};
    cnt = cnt + 1;
  end
  always @(negedge mdc)
    mdio_i = (cnt >= 48 && cnt < 64) ? cur_resp[63-cnt] : 1'b1;

  logic pmdc = 0, pdat = 0;
  always @(negedge clk) begin
    if (pmdc && mdc && (pdat !== mdio_o)) r6_bad++;
    pmdc = mdc; pdat = mdio_o;
  end

  function automatic logic [15:0] resp(input logic [4:0] p, input logic [4:0] r);
    return {r, p, 6'h15} ^ 16'hA5C3;
  endfunction
  function automatic logic [63:0] frame(input bit rd, input logic [4:0] p,
                                        input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, p, r, 2'b10, d};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #0.5;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic reg_rd(input logic [7:0] a, output logic [15:0] d);
    rd_addr = a; #0.1; d = rd_data;
  endtask

  task automatic wait_done(output int n);
    logic [15:0] v;
    n = 0;
    do begin
      @(negedge clk); n++; reg_rd(8'h20, v);
    end while ((v[14] || v[13]) && n < 4096);
  endtask

  task automatic run_op(input bit rd, input logic [4:0] p, input logic [4:0] r,
                        input logic [15:0] d, input bit both);
    logic [15:0] v, cmdw;
    int n;
    logic [63:0] ef;
    if (!rd) reg_wr(8'h28, d);
    cnt = 0; cur_resp = resp(p, r);
    cmdw = {1'b0, both | ~rd, rd | both, p, 3'b000, r};
    @(negedge clk); wr_en = 1; wr_addr = 8'h20; wr_data = cmdw;
    @(posedge clk); #0.5;
    @(negedge clk); wr_en = 0;
    reg_rd(8'h20, v);
    chk(v == {1'b0, ~rd, rd, p, 3'b0, r}, "R2 request bit", v, {1'b0, ~rd, rd, p, 3'b0, r});
    wait_done(n);
    chk(n == 128*DIV, "R7 completion time", n, 128*DIV);
    reg_rd(8'h20, v);
    chk(v == {3'b0, p, 3'b0, r}, "R7 fields kept", v, {3'b0, p, 3'b0, r});
    chk(cnt == 64, "R5 MDC rising count", cnt, 64);
    ef = frame(rd, p, r, d);
    if (rd) begin
      chk(cap[63:18] == ef[63:18], "R4 read header", cap, ef);
      chk(oev == {{46{1'b1}}, 18'h0}, "R4 release window", oev, {{46{1'b1}}, 18'h0});
      reg_rd(8'h24, v);
      chk(v == cur_resp, "R4 read result", v, cur_resp);
    end else begin
      chk(cap == ef, "R3 write frame", cap, ef);
      chk(oev == '1, "R3 driven throughout", oev, '1);
    end
    #0.1;
    chk(!mdc && !mdio_oe, "R5 idle bus", {mdc, mdio_oe}, 0);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int n, seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    reg_rd(8'h20, v); chk(v == 0, "R1 cmd reset", v, 0);
    reg_rd(8'h24, v); chk(v == 0, "R1 result reset", v, 0);
    reg_rd(8'h28, v); chk(v == 0, "R1 wdata reset", v, 0);
    chk(!mdc && !mdio_oe, "R1 bus reset", {mdc, mdio_oe}, 0);
    rst_n = 1;
    @(negedge clk);

    reg_wr(8'h28, 16'hBEEF);
    reg_rd(8'h28, v); chk(v == 16'hBEEF, "R9 wdata readback", v, 16'hBEEF);
    reg_rd(8'h5C, v); chk(v == 0, "R9 unmapped offset", v, 0);

    run_op(0, 5'd0, 5'd0, 16'h0000, 0);
    run_op(0, 5'h1F, 5'h1F, 16'hFFFF, 0);
    run_op(1, 5'h1D, 5'h02, 16'h0, 0);
    run_op(1, 5'h15, 5'h0A, 16'h0, 1);

    reg_wr(8'h20, {3'b0, 5'h07, 3'b0, 5'h09});
    reg_rd(8'h20, v);
    chk(v == {3'b0, 5'h15, 3'b0, 5'h0A}, "R8 no-request write ignored", v, {3'b0, 5'h15, 3'b0, 5'h0A});
    repeat (20) @(negedge clk);
    chk(!mdc && !mdio_oe, "R8 no frame started", {mdc, mdio_oe}, 0);

    reg_wr(8'h28, 16'h1234);
    cnt = 0;
    reg_wr(8'h20, {1'b0, 1'b1, 1'b0, 5'h03, 3'b0, 5'h04});
    repeat (37) @(negedge clk);
    reg_wr(8'h20, {1'b0, 1'b0, 1'b1, 5'h11, 3'b0, 5'h12});
    wait_done(n);
    reg_rd(8'h20, v);
    chk(v == {3'b0, 5'h03, 3'b0, 5'h04}, "R8 busy command ignored", v, {3'b0, 5'h03, 3'b0, 5'h04});
    chk(cap == frame(0, 5'h03, 5'h04, 16'h1234), "R8 frame unchanged", cap, frame(0, 5'h03, 5'h04, 16'h1234));
    repeat (10) @(negedge clk);
    chk(cnt == 64, "R8 no second frame", cnt, 64);

    for (int i = 0; i < 20; i++) begin
      logic [4:0] p, r;
      logic [15:0] d;
      bit rd;
      p = 5'($urandom); r = 5'($urandom); d = 16'($urandom); rd = 1'($urandom);
      run_op(rd, p, r, d, 0);
    end

    chk(r6_bad == 0, "R6 data steady while MDC high", r6_bad, 0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule